// File: doc/BRIEF.md
# Alarm Match and Interrupt Pin Control

This block decides when the calendar alarm fires and what the single shared open-drain output pin does. On every seconds tick it compares the running BCD time (seconds, minutes, hours, day of month, month) with the programmed alarm fields. A 5-bit repeat code chooses which fields take part in the compare. A hit sets a sticky alarm flag, which a read of the flags register clears.

The same block arbitrates the output pin among four users: the alarm interrupt, the watchdog interrupt, a 512 Hz test tone and the square wave or a static output level. Which user wins depends on the enable bits, the watchdog setting, the oscillator stop bit and the backup-mode state. The block does not count the watchdog and does not divide the square wave. Both arrive as ready signals from neighbouring logic. The block produces only the pull-down enable for the pad and the flag.

Top module: `alarm_pin_ctl`

## Requirements
- R1: After reset the alarm flag `af` is 0 and `pin_pull` is 0 while all pin sources are idle and `out_lvl` is 1.
- R2: With repeat code `rpt_code` = 5'b11111, every seconds tick sets `af`, whatever the time and alarm values are. Bit 4 is the month mask, then date, hour and minute, down to bit 0 for seconds. A field is compared only when its bit is 0.
- R3: With code 5'b11110, a tick sets `af` only if the seconds match.
- R4: Codes 5'b11100, 5'b11000 and 5'b10000 add minutes, then hours, then date to the compare. A mismatch in a field that is not compared does not prevent the flag from being set.
- R5: With code 5'b00000, all five fields including the month must match.
- R6: Any code other than the six legal ones behaves as 5'b11111.
- R7: `af` is set only in a cycle where `sec_tick` is 1. A match without a tick leaves `af` at 0.
- R8: A `flags_rd` strobe clears `af` at the next clock edge. If a tick hit arrives in the same cycle, the hit wins and `af` stays 1.
- R9: In normal mode with `afe`=1 and `sqwe`=0, `pin_pull` is 1 while `af` is 1, unless `ptr` equals 5'h0F (the flags address). The pin is released while `ptr` is 5'h0F and is pulled again once `ptr` moves away.
- R10: When `backup` is 1, the pin is pulled only when `af`, `abe` and `afe` are all 1. Every other source is silenced.
- R11: When `wd_cfg` is nonzero and `sqwe`=0, the pin carries the watchdog interrupt `wd_irq` (pulled when 1), and the test tone is blocked even when `ft`=1.
- R12: With `ft`=1, `afe`=0, `sqwe`=0 and `wd_cfg`=0, the pin pulls while `ft_clk` is 0 if `st`=0. With `st`=1 the pin is released.
- R13: With `sqwe`=1 in normal mode, the pin pulls while `sqw_clk` is 0.
- R14: With `ft`, `afe` and `sqwe` all 0 and `wd_cfg`=0, the pin pulls exactly when `out_lvl` is 0.
- All pin results appear one clock after their inputs, and `af` updates at the edge that samples the tick or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 6 | Current hours, BCD |
| tm_date | input | 6 | Current day of month, BCD |
| tm_month | input | 5 | Current month, BCD |
| al_sec | input | 7 | Alarm seconds, BCD |
| al_min | input | 7 | Alarm minutes, BCD |
| al_hour | input | 6 | Alarm hours, BCD |
| al_date | input | 6 | Alarm day of month, BCD |
| al_month | input | 5 | Alarm month, BCD |
| rpt_code | input | 5 | Repeat mask: bit 4 month down to bit 0 seconds |
| afe | input | 1 | Alarm interrupt enable |
| sqwe | input | 1 | Square wave enable |
| abe | input | 1 | Alarm allowed in backup mode |
| ft | input | 1 | Frequency test enable |
| st | input | 1 | Oscillator stopped |
| out_lvl | input | 1 | Static pin level when nothing else drives it |
| wd_cfg | input | 8 | Watchdog setting, nonzero means armed |
| wd_irq | input | 1 | Watchdog interrupt from the watchdog counter |
| ft_clk | input | 1 | 512 Hz test tone |
| sqw_clk | input | 1 | Divided square wave |
| flags_rd | input | 1 | Strobe for a read of the flags register |
| ptr | input | 5 | Current register pointer |
| backup | input | 1 | Device is in backup mode |
| pin_pull | output | 1 | Pull-down enable of the open-drain pin |
| af | output | 1 | Alarm flag |

## Verification
The compare is driven with one field mismatched at a time under each legal repeat code. This shows that each code masks exactly the intended fields and no more. An illegal code with every field mismatched separates the fallback from a literal decode. Pin tests move one enable at a time across the priority boundaries: watchdog against test tone, flags pointer against alarm, backup against normal mode. Each test selects a case where the wrong winner would give the opposite pin level. A tick coinciding with a flags read shows which of the two takes precedence.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
  localparam int NFLD = 5;
  // field order, LSB first: seconds, minutes, hours, date, month
  localparam int FLD_W [NFLD] = '{7, 7, 6, 6, 5};

  function automatic int fld_lo(input int idx);
    int s;
    s = 0;
    for (int j = 0; j < idx; j++) s += FLD_W[j];
    return s;
  endfunction

  localparam int TV_W = fld_lo(NFLD);

  typedef enum logic [2:0] {
    PS_BACKUP,
    PS_IRQ,
    PS_SQW,
    PS_TONE,
    PS_LEVEL
  } pin_src_e;
endpackage

// File: rtl/alarm_rpt_decode.sv
`timescale 1ns/1ps
module alarm_rpt_decode #(
  parameter int NF = 5
) (
  input  logic [NF-1:0] code,
  output logic [NF-1:0] cmp_en
);
  logic          legal;
  logic [NF-1:0] eff;

  // legal codes: ones packed from the top, zeros below (k ones, k = 0..NF)
  always_comb begin
    legal = 1'b0;
    for (int k = 0; k <= NF; k++) begin
      if (code == ~({NF{1'b1}} >> k)) legal = 1'b1;
    end
    eff    = legal ? code : {NF{1'b1}};
    cmp_en = ~eff;
  end
endmodule

// File: rtl/alarm_match.sv
`timescale 1ns/1ps
module alarm_match
  import alarm_pkg::*;
#(
  parameter int W = TV_W
) (
  input  logic [W-1:0]    tv,
  input  logic [W-1:0]    av,
  input  logic [NFLD-1:0] cmp_en,
  output logic            hit
);
  logic [NFLD-1:0] fld_ok;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam int LO = fld_lo(i);
    localparam int FW = FLD_W[i];
    assign fld_ok[i] = !cmp_en[i] || (tv[LO +: FW] == av[LO +: FW]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/alarm_flag_reg.sv
`timescale 1ns/1ps
module alarm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  output logic af
);
  logic af_q, af_d;

  always_comb begin
    af_d = af_q;
    if (clr)        af_d = 1'b0;
    if (tick && hit) af_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) af_q <= 1'b0;
    else        af_q <= af_d;
  end

  assign af = af_q;
endmodule

// File: rtl/pin_arbiter.sv
`timescale 1ns/1ps
module pin_arbiter
  import alarm_pkg::*;
#(
  parameter int              WD_W       = 8,
  parameter int              PTR_W      = 5,
  parameter logic [PTR_W-1:0] FLAGS_ADDR = 5'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             af,
  input  logic             afe,
  input  logic             sqwe,
  input  logic             abe,
  input  logic             ft,
  input  logic             st,
  input  logic             out_lvl,
  input  logic [WD_W-1:0]  wd_cfg,
  input  logic             wd_irq,
  input  logic             ft_clk,
  input  logic             sqw_clk,
  input  logic [PTR_W-1:0] ptr,
  input  logic             backup,
  output logic             pin_pull
);
  logic     wd_armed, on_flags, pull_d, pull_q;
  pin_src_e src;

  assign wd_armed = |wd_cfg;
  assign on_flags = (ptr == FLAGS_ADDR);

  always_comb begin
    if (backup)                          src = PS_BACKUP;
    else if (!sqwe && (afe || wd_armed)) src = PS_IRQ;
    else if (sqwe)                       src = PS_SQW;
    else if (ft)                         src = PS_TONE;
    else                                 src = PS_LEVEL;
  end

  always_comb begin
    unique case (src)
      PS_BACKUP: pull_d = af && abe && afe;
      PS_IRQ:    pull_d = (afe && af && !on_flags) || (wd_armed && wd_irq);
      PS_SQW:    pull_d = !sqw_clk;
      PS_TONE:   pull_d = !st && !ft_clk;
      default:   pull_d = !out_lvl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pull_d;
  end

  assign pin_pull = pull_q;
endmodule

// File: rtl/alarm_pin_ctl.sv
`timescale 1ns/1ps
module alarm_pin_ctl
  import alarm_pkg::*;
#(
  parameter int               WD_W       = 8,
  parameter int               PTR_W      = 5,
  parameter logic [PTR_W-1:0] FLAGS_ADDR = 5'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [6:0]       tm_sec,
  input  logic [6:0]       tm_min,
  input  logic [5:0]       tm_hour,
  input  logic [5:0]       tm_date,
  input  logic [4:0]       tm_month,
  input  logic [6:0]       al_sec,
  input  logic [6:0]       al_min,
  input  logic [5:0]       al_hour,
  input  logic [5:0]       al_date,
  input  logic [4:0]       al_month,
  input  logic [NFLD-1:0]  rpt_code,
  input  logic             afe,
  input  logic             sqwe,
  input  logic             abe,
  input  logic             ft,
  input  logic             st,
  input  logic             out_lvl,
  input  logic [WD_W-1:0]  wd_cfg,
  input  logic             wd_irq,
  input  logic             ft_clk,
  input  logic             sqw_clk,
  input  logic             flags_rd,
  input  logic [PTR_W-1:0] ptr,
  input  logic             backup,
  output logic             pin_pull,
  output logic             af
);
  logic [1:0]      rst_sync;
  logic            rst_q;
  logic [TV_W-1:0] tv, av;
  logic [NFLD-1:0] cmp_en;
  logic            hit;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign tv = {tm_month, tm_date, tm_hour, tm_min, tm_sec};
  assign av = {al_month, al_date, al_hour, al_min, al_sec};

  alarm_rpt_decode #(.NF(NFLD)) u_dec (
    .code   (rpt_code),
    .cmp_en (cmp_en)
  );

  alarm_match #(.W(TV_W)) u_match (
    .tv     (tv),
    .av     (av),
    .cmp_en (cmp_en),
    .hit    (hit)
  );

  alarm_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_q),
    .tick  (sec_tick),
    .hit   (hit),
    .clr   (flags_rd),
    .af    (af)
  );

  pin_arbiter #(.WD_W(WD_W), .PTR_W(PTR_W), .FLAGS_ADDR(FLAGS_ADDR)) u_pin (
    .clk      (clk),
    .rst_n    (rst_q),
    .af       (af),
    .afe      (afe),
    .sqwe     (sqwe),
    .abe      (abe),
    .ft       (ft),
    .st       (st),
    .out_lvl  (out_lvl),
    .wd_cfg   (wd_cfg),
    .wd_irq   (wd_irq),
    .ft_clk   (ft_clk),
    .sqw_clk  (sqw_clk),
    .ptr      (ptr),
    .backup   (backup),
    .pin_pull (pin_pull)
  );
endmodule

// File: rtl/alarm_pin_chk.sv
`timescale 1ns/1ps
module alarm_pin_chk #(
  parameter int               WD_W       = 8,
  parameter int               PTR_W      = 5,
  parameter logic [PTR_W-1:0] FLAGS_ADDR = 5'h0F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             flags_rd,
  input logic [PTR_W-1:0] ptr,
  input logic             afe,
  input logic             sqwe,
  input logic             abe,
  input logic             ft,
  input logic             backup,
  input logic [WD_W-1:0]  wd_cfg,
  input logic             sqw_clk,
  input logic             out_lvl,
  input logic             af,
  input logic             pin_pull
);
  // edges seen since reset, saturating; the block is live after the sync stage
  logic [1:0] seen;
  logic       live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end
  assign live = (seen == 2'd3);

  AST_AF_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(af)) |-> $past(sec_tick)); // R7

  AST_AF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (live && flags_rd && !sec_tick) |=> !af); // R8

  AST_FLAGS_PTR_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !backup && afe && !sqwe && wd_cfg == '0 && ptr == FLAGS_ADDR) |=> !pin_pull); // R9

  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && backup && !(abe && afe)) |=> !pin_pull); // R10

  AST_SQW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !backup && sqwe) |=> (pin_pull == !$past(sqw_clk))); // R13

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !backup && !sqwe && !afe && !ft && wd_cfg == '0) |=> (pin_pull == !$past(out_lvl))); // R14

  AST_NO_PULL_IN_RESET: assert property (@(posedge clk)
    (!rst_n) |-> !pin_pull && !af); // R1
endmodule

bind alarm_pin_ctl alarm_pin_chk #(.WD_W(WD_W), .PTR_W(PTR_W), .FLAGS_ADDR(FLAGS_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .flags_rd (flags_rd),
  .ptr      (ptr),
  .afe      (afe),
  .sqwe     (sqwe),
  .abe      (abe),
  .ft       (ft),
  .backup   (backup),
  .wd_cfg   (wd_cfg),
  .sqw_clk  (sqw_clk),
  .out_lvl  (out_lvl),
  .af       (af),
  .pin_pull (pin_pull)
);

// File: tb/sim_alarm_pin_ctl.sv
`timescale 1ns/1ps
module sim_alarm_pin_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick, afe, sqwe, abe, ft, st, out_lvl, wd_irq, ft_clk, sqw_clk, flags_rd, backup;
  logic [6:0] tm_sec, tm_min, al_sec, al_min;
  logic [5:0] tm_hour, tm_date, al_hour, al_date;
  logic [4:0] tm_month, al_month, rpt_code, ptr;
  logic [7:0] wd_cfg;
  logic       pin_pull, af;

  typedef struct {
    logic  af;
    logic  pin;
    string tag;
  } exp_t;

  exp_t  sb[$];
  event  chk_ev;
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;

  always #2.5 clk = ~clk;

  alarm_pin_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date), .tm_month(tm_month),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .al_date(al_date), .al_month(al_month),
    .rpt_code(rpt_code), .afe(afe), .sqwe(sqwe), .abe(abe), .ft(ft), .st(st), .out_lvl(out_lvl),
    .wd_cfg(wd_cfg), .wd_irq(wd_irq), .ft_clk(ft_clk), .sqw_clk(sqw_clk), .flags_rd(flags_rd),
    .ptr(ptr), .backup(backup), .pin_pull(pin_pull), .af(af)
  );

  // monitor: pops an expected item each time the driver announces a result
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (af !== e.af || pin_pull !== e.pin) begin
          miscompares++;
          $display("FAIL %s: af=%b pin_pull=%b expected af=%b pin_pull=%b",
                   e.tag, af, pin_pull, e.af, e.pin);
        end
      end
    end
  end

  task automatic expect_out(input logic e_af, input logic e_pin, input string tag);
    exp_t e;
    repeat (2) @(negedge clk);
    e.af = e_af; e.pin = e_pin; e.tag = tag;
    sb.push_back(e);
    -> chk_ev;
    #0.1;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic read_flags();
    @(negedge clk) flags_rd = 1'b1;
    @(negedge clk) flags_rd = 1'b0;
  endtask

  task automatic alarm_eq();
    al_sec = tm_sec; al_min = tm_min; al_hour = tm_hour; al_date = tm_date; al_month = tm_month;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; afe = 0; sqwe = 0; abe = 0; ft = 0; st = 0; out_lvl = 1;
    wd_irq = 0; ft_clk = 1; sqw_clk = 1; flags_rd = 0; backup = 0; ptr = 5'h03; wd_cfg = 8'h00;
    tm_sec = 7'h45; tm_min = 7'h30; tm_hour = 6'h12; tm_date = 6'h15; tm_month = 5'h06;
    alarm_eq();
    rpt_code = 5'b11111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(1'b0, 1'b0, "R1 reset state");

    // R14 static level
    out_lvl = 1'b0; expect_out(1'b0, 1'b1, "R14 out_lvl=0 pulls");
    out_lvl = 1'b1; expect_out(1'b0, 1'b0, "R14 out_lvl=1 releases");

    // R7 match without tick
    rpt_code = 5'b00000; expect_out(1'b0, 1'b0, "R7 no tick no flag");

    // R2 every second
    rpt_code = 5'b11111; al_sec = 7'h11; al_month = 5'h01;
    tick(); expect_out(1'b1, 1'b0, "R2 every-second sets");
    read_flags(); expect_out(1'b0, 1'b0, "R8 flags read clears");

    // R3 seconds compared
    rpt_code = 5'b11110; al_sec = 7'h44; al_min = 7'h00;
    tick(); expect_out(1'b0, 1'b0, "R3 seconds mismatch");
    al_sec = 7'h45;
    tick(); expect_out(1'b1, 1'b0, "R3 seconds match, minutes ignored");
    read_flags();

    // R4 hour/day/month codes
    alarm_eq(); rpt_code = 5'b11100; al_hour = 6'h05;
    tick(); expect_out(1'b1, 1'b0, "R4 11100 hour ignored");
    read_flags(); al_min = 7'h31;
    tick(); expect_out(1'b0, 1'b0, "R4 11100 minute compared");
    alarm_eq(); rpt_code = 5'b11000; al_date = 6'h01;
    tick(); expect_out(1'b1, 1'b0, "R4 11000 date ignored");
    read_flags(); al_hour = 6'h13;
    tick(); expect_out(1'b0, 1'b0, "R4 11000 hour compared");
    alarm_eq(); rpt_code = 5'b10000; al_month = 5'h12;
    tick(); expect_out(1'b1, 1'b0, "R4 10000 month ignored");
    read_flags(); al_date = 6'h16;
    tick(); expect_out(1'b0, 1'b0, "R4 10000 date compared");

    // R5 yearly
    alarm_eq(); rpt_code = 5'b00000; al_month = 5'h07;
    tick(); expect_out(1'b0, 1'b0, "R5 month compared");
    al_month = 5'h06;
    tick(); expect_out(1'b1, 1'b0, "R5 full match");
    read_flags();

    // R6 illegal code
    rpt_code = 5'b10101; al_sec = 7'h00; al_min = 7'h00; al_hour = 6'h00; al_date = 6'h01; al_month = 5'h01;
    tick(); expect_out(1'b1, 1'b0, "R6 illegal code fires every second");

    // R8 simultaneous tick and read
    @(negedge clk) begin sec_tick = 1'b1; flags_rd = 1'b1; end
    @(negedge clk) begin sec_tick = 1'b0; flags_rd = 1'b0; end
    expect_out(1'b1, 1'b0, "R8 hit beats clear");

    // R9 alarm interrupt and pointer mute
    afe = 1'b1; expect_out(1'b1, 1'b1, "R9 alarm pulls pin");
    ptr = 5'h0F; expect_out(1'b1, 1'b0, "R9 pointer on flags mutes");
    ptr = 5'h0A; expect_out(1'b1, 1'b1, "R9 pointer moved re-asserts");
    read_flags(); expect_out(1'b0, 1'b0, "R9 flags read releases");

    // R10 backup mode
    tick(); backup = 1'b1;
    expect_out(1'b1, 1'b0, "R10 backup without abe");
    abe = 1'b1; expect_out(1'b1, 1'b1, "R10 backup with abe and afe");
    afe = 1'b0; out_lvl = 1'b0; expect_out(1'b1, 1'b0, "R10 backup silences level");
    read_flags(); backup = 1'b0; abe = 1'b0; out_lvl = 1'b1;
    rpt_code = 5'b00000;
    expect_out(1'b0, 1'b0, "R10 back to normal idle");

    // R11 watchdog beats tone
    wd_cfg = 8'h05; ft = 1'b1; ft_clk = 1'b0; wd_irq = 1'b0;
    expect_out(1'b0, 1'b0, "R11 tone blocked by watchdog");
    wd_irq = 1'b1; expect_out(1'b0, 1'b1, "R11 watchdog irq pulls");
    wd_irq = 1'b0; wd_cfg = 8'h00;

    // R12 test tone
    ft_clk = 1'b0; expect_out(1'b0, 1'b1, "R12 tone low pulls");
    ft_clk = 1'b1; expect_out(1'b0, 1'b0, "R12 tone high releases");
    st = 1'b1; ft_clk = 1'b0; expect_out(1'b0, 1'b0, "R12 stopped oscillator releases");
    st = 1'b0; ft = 1'b0;

    // R13 square wave
    sqwe = 1'b1; sqw_clk = 1'b0; expect_out(1'b0, 1'b1, "R13 square low pulls");
    sqw_clk = 1'b1; expect_out(1'b0, 1'b0, "R13 square high releases");
    rpt_code = 5'b11111; afe = 1'b1; tick();
    expect_out(1'b1, 1'b0, "R13 square wave overrides alarm");

    done = 1;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule